// File: doc/BRIEF.md
# Transceiver Status and Control Byte

This block holds the one-byte status/control word of a pluggable optical transceiver. Five hardware pins (transmit disable, the two rate-select lines, transmit fault and receive loss of signal) are brought into the clock domain through a synchroniser. A slow periodic sampler then latches them into the byte, so software sees pin states refreshed at a fixed rate that stays well inside the 100 ms freshness limit. The two register bits that software can write, a soft laser disable and a soft full-bandwidth select, are each ORed with the matching synchronised pin to drive the effective control outputs.

The lowest bit is an active-low readiness flag. It reads 1 from reset and drops to 0 once the measurement path raises `data_valid`, and then stays 0 until the next reset. Each soft control can be removed by a parameter. When it is removed, writes to its bit are ignored, the bit reads 0, and the output follows the pin alone.

Top module: `xcvr_stat_ctrl`

## Requirements
- R1: The read byte `rd_data` is laid out as: bit 7 transmit-disable pin, bit 6 soft laser disable, bit 5 RS1 pin, bit 4 rate-select (RS0) pin, bit 3 soft full-bandwidth, bit 2 transmit-fault pin, bit 1 loss-of-signal pin, bit 0 not-ready.
- R2: `laser_off` is the OR of the soft laser disable bit and the synchronised transmit-disable pin. A pin change reaches `laser_off` after SYNC_STAGES clock edges.
- R3: `full_bw` is the OR of the soft full-bandwidth bit and the synchronised rate-select pin, with the same latency as R2.
- R4: After reset both soft bits are 0, the not-ready bit is 1, and all pin bits read 0 until the first sample tick, so `rd_data` is 8'h01.
- R5: A write (`wr_en` high at a clock edge) loads `wr_data[6]` and `wr_data[3]` into the two soft bits. Writes to every other bit position are ignored.
- R6: The pin bits are refreshed by a sample tick every SAMPLE_DIV cycles and are held between ticks. A pin change appears in `rd_data` within SYNC_STAGES + SAMPLE_DIV + 1 cycles.
- R7: `data_valid` high at a clock edge clears the not-ready bit. The bit stays 0 until reset, whatever `data_valid` does afterwards.
- R8: With SOFT_TXDIS_EN or SOFT_RATE_EN set to 0, writes to that soft bit are ignored, the bit reads 0, and the matching output follows its pin alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for the control byte |
| wr_data | input | 8 | Write data; only bits 6 and 3 are used |
| rd_data | output | 8 | Status/control byte |
| pin_txdis | input | 1 | Hardware transmit-disable pin |
| pin_rs1 | input | 1 | Hardware RS1 pin |
| pin_rs0 | input | 1 | Hardware rate-select (RS0) pin |
| pin_txfault | input | 1 | Transmit-fault pin |
| pin_rxlos | input | 1 | Receive loss-of-signal pin |
| data_valid | input | 1 | Measurement data is ready |
| laser_off | output | 1 | Effective laser disable |
| full_bw | output | 1 | Effective full-bandwidth select |

## Verification
A soft bit that is wrong internally shows up in the same cycle on `rd_data` and on `laser_off` or `full_bw`, because both are driven straight from the register. A broken synchroniser or sampler shows as a pin bit that is stale beyond SYNC_STAGES + SAMPLE_DIV + 1 cycles, or that changes between ticks. A readiness flag that is wrong shows as bit 0 being set again after it has cleared, or failing to clear one cycle after `data_valid`. The bench holds each random pin and write pattern for longer than a full sample window, then compares the byte and both outputs with a model.

// File: rtl/xsc_pkg.sv
package xsc_pkg;
    localparam int NPIN = 5;
    // pin vector positions
    localparam int P_TXDIS = 0;
    localparam int P_RS1   = 1;
    localparam int P_RS0   = 2;
    localparam int P_FAULT = 3;
    localparam int P_LOS   = 4;

    typedef struct packed {
        logic            soft_tx;
        logic            soft_rate;
        logic            not_ready;
        logic [NPIN-1:0] snap;
    } xsc_state_t;

    function automatic logic [7:0] pack_byte(xsc_state_t s);
        return {s.snap[P_TXDIS], s.soft_tx, s.snap[P_RS1], s.snap[P_RS0],
                s.soft_rate, s.snap[P_FAULT], s.snap[P_LOS], s.not_ready};
    endfunction
endpackage

// File: rtl/xsc_sync.sv
module xsc_sync #(
    parameter int W      = 5,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stage_q [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage_q[i] <= '0;
            end else if (i == 0) begin
                stage_q[i] <= din;
            end else begin
                stage_q[i] <= stage_q[(i == 0) ? 0 : i-1];
            end
        end
    end

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/xsc_tick.sv
module xsc_tick #(
    parameter int DIV = 100000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign tick = (cnt_q == LAST);
endmodule

// File: rtl/xsc_core.sv
module xsc_core
    import xsc_pkg::*;
#(
    parameter bit SOFT_TXDIS_EN = 1'b1,
    parameter bit SOFT_RATE_EN  = 1'b1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic            wr_tx,
    input  logic            wr_rate,
    input  logic            tick,
    input  logic [NPIN-1:0] pins_s,
    input  logic            data_valid,
    output xsc_state_t      state
);
    xsc_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.soft_tx   = SOFT_TXDIS_EN ? wr_tx   : 1'b0;
            st_d.soft_rate = SOFT_RATE_EN  ? wr_rate : 1'b0;
        end
        if (tick)       st_d.snap      = pins_s;
        if (data_valid) st_d.not_ready = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.soft_tx   <= 1'b0;
            st_q.soft_rate <= 1'b0;
            st_q.not_ready <= 1'b1;
            st_q.snap      <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign state = st_q;
endmodule

// File: rtl/xcvr_stat_ctrl.sv
module xcvr_stat_ctrl
    import xsc_pkg::*;
#(
    parameter int SAMPLE_DIV    = 100000,
    parameter int SYNC_STAGES   = 2,
    parameter bit SOFT_TXDIS_EN = 1'b1,
    parameter bit SOFT_RATE_EN  = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    input  logic       pin_txdis,
    input  logic       pin_rs1,
    input  logic       pin_rs0,
    input  logic       pin_txfault,
    input  logic       pin_rxlos,
    input  logic       data_valid,
    output logic       laser_off,
    output logic       full_bw
);
    logic [NPIN-1:0] pins_raw, pins_s;
    logic            sample_tick;
    xsc_state_t      state;
    logic            unused_wr;

    assign unused_wr = ^{wr_data[7], wr_data[5:4], wr_data[2:0]};

    always_comb begin
        pins_raw          = '0;
        pins_raw[P_TXDIS] = pin_txdis;
        pins_raw[P_RS1]   = pin_rs1;
        pins_raw[P_RS0]   = pin_rs0;
        pins_raw[P_FAULT] = pin_txfault;
        pins_raw[P_LOS]   = pin_rxlos;
    end

    xsc_sync #(.W(NPIN), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(pins_raw), .dout(pins_s)
    );

    xsc_tick #(.DIV(SAMPLE_DIV)) u_tick (
        .clk(clk), .rst_n(rst_n), .tick(sample_tick)
    );

    xsc_core #(.SOFT_TXDIS_EN(SOFT_TXDIS_EN), .SOFT_RATE_EN(SOFT_RATE_EN)) u_core (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
        .wr_tx(wr_data[6]), .wr_rate(wr_data[3]),
        .tick(sample_tick), .pins_s(pins_s),
        .data_valid(data_valid), .state(state)
    );

    assign rd_data   = pack_byte(state);
    assign laser_off = state.soft_tx   | pins_s[P_TXDIS];
    assign full_bw   = state.soft_rate | pins_s[P_RS0];
endmodule

// File: rtl/xsc_checker.sv
module xsc_checker
    import xsc_pkg::*;
#(
    parameter int SAMPLE_DIV    = 100000,
    parameter bit SOFT_TXDIS_EN = 1'b1,
    parameter bit SOFT_RATE_EN  = 1'b1
) (
    input logic            clk,
    input logic            rst_n,
    input logic            sample_tick,
    input logic [NPIN-1:0] pins_s,
    input logic [7:0]      rd_data,
    input logic            laser_off,
    input logic            full_bw,
    input logic            data_valid
);
    logic [31:0] since_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           since_q <= '0;
        else if (sample_tick) since_q <= '0;
        else                  since_q <= since_q + 1;
    end

    a_r2_soft_forces_off: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[6] |-> laser_off);
    a_r2_pin_forces_off: assert property (@(posedge clk) disable iff (!rst_n)
        pins_s[P_TXDIS] |-> laser_off);
    a_r3_soft_forces_bw: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[3] |-> full_bw);
    a_r6_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_tick |=> $stable({rd_data[7], rd_data[5:4], rd_data[2:1]}));
    a_r6_tick_period: assert property (@(posedge clk) disable iff (!rst_n)
        since_q < SAMPLE_DIV);
    a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
        data_valid |=> !rd_data[0]);
    a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_data[0] |=> !rd_data[0]);
    a_r8_tx_absent: assert property (@(posedge clk) disable iff (!rst_n)
        SOFT_TXDIS_EN || !rd_data[6]);
    a_r8_rate_absent: assert property (@(posedge clk) disable iff (!rst_n)
        SOFT_RATE_EN || !rd_data[3]);
endmodule

bind xcvr_stat_ctrl xsc_checker #(
    .SAMPLE_DIV(SAMPLE_DIV), .SOFT_TXDIS_EN(SOFT_TXDIS_EN), .SOFT_RATE_EN(SOFT_RATE_EN)
) u_chk (
    .clk(clk), .rst_n(rst_n), .sample_tick(sample_tick), .pins_s(pins_s),
    .rd_data(rd_data), .laser_off(laser_off), .full_bw(full_bw), .data_valid(data_valid)
);

// File: tb/sim_xcvr_stat_ctrl.sv
module sim_xcvr_stat_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int DIV        = 16;
    localparam int SYNC       = 2;
    localparam int SETTLE     = SYNC + DIV + 1;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       pin_txdis = 1'b0, pin_rs1 = 1'b0, pin_rs0 = 1'b0;
    logic       pin_txfault = 1'b0, pin_rxlos = 1'b0, data_valid = 1'b0;
    logic [7:0] rd0, rd1;
    logic       laser0, bw0, laser1, bw1;

    int n_checks = 0;
    int n_errors = 0;
    logic m_tx = 1'b0, m_rate = 1'b0, m_nr = 1'b1;

    always #(CLK_PERIOD/2) clk = ~clk;

    xcvr_stat_ctrl #(.SAMPLE_DIV(DIV), .SYNC_STAGES(SYNC)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd0),
        .pin_txdis(pin_txdis), .pin_rs1(pin_rs1), .pin_rs0(pin_rs0),
        .pin_txfault(pin_txfault), .pin_rxlos(pin_rxlos), .data_valid(data_valid),
        .laser_off(laser0), .full_bw(bw0));

    xcvr_stat_ctrl #(.SAMPLE_DIV(DIV), .SYNC_STAGES(SYNC),
                     .SOFT_TXDIS_EN(1'b0), .SOFT_RATE_EN(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd1),
        .pin_txdis(pin_txdis), .pin_rs1(pin_rs1), .pin_rs0(pin_rs0),
        .pin_txfault(pin_txfault), .pin_rxlos(pin_rxlos), .data_valid(data_valid),
        .laser_off(laser1), .full_bw(bw1));

    function automatic logic [7:0] exp_byte(logic tx, logic rate, logic nr);
        return {pin_txdis, tx, pin_rs1, pin_rs0, rate, pin_txfault, pin_rxlos, nr};
    endfunction

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic cyc(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(logic [7:0] v);
        wr_data = v; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        m_tx = v[6]; m_rate = v[3];
    endtask

    task automatic check_all(string tag);
        chk({tag, " R1 R5 byte u0"}, rd0, exp_byte(m_tx, m_rate, m_nr));
        chk({tag, " R2 laser u0"}, {7'd0, laser0}, {7'd0, m_tx | pin_txdis});
        chk({tag, " R3 bw u0"}, {7'd0, bw0}, {7'd0, m_rate | pin_rs0});
        chk({tag, " R8 byte u1"}, rd1, exp_byte(1'b0, 1'b0, m_nr));
        chk({tag, " R8 outs u1"}, {6'd0, laser1, bw1}, {6'd0, pin_txdis, pin_rs0});
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_errors++; n_checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin : main
        int seed;
        seed = $urandom(32'd20240611);
        pin_txdis = 1'b1; pin_rs0 = 1'b1; pin_rxlos = 1'b1;
        cyc(3);
        rst_n = 1'b1;
        @(negedge clk);
        // R4: reset state, pins not yet sampled
        chk("R4 reset byte", rd0, 8'h01);
        chk("R4 reset byte u1", rd1, 8'h01);
        cyc(SETTLE + 1);
        check_all("R6 first sample");

        // R5: only bits 6 and 3 take; others ignored
        wr(8'hB7);
        chk("R5 write B7 no soft bits", rd0, exp_byte(1'b0, 1'b0, 1'b1));
        wr(8'h48);
        check_all("R5 write 48");
        pin_txdis = 1'b0; pin_rs0 = 1'b0;
        cyc(SYNC);
        // R2/R3: outputs still forced by soft bits, pins synced
        chk("R2 soft holds laser", {7'd0, laser0}, 8'd1);
        chk("R3 soft holds bw", {7'd0, bw0}, 8'd1);
        chk("R8 u1 laser follows pin", {7'd0, laser1}, 8'd0);
        wr(8'h00);
        chk("R2 laser released", {7'd0, laser0}, 8'd0);
        // R2 latency: pin change visible after SYNC edges
        pin_txdis = 1'b1;
        cyc(SYNC - 1);
        chk("R2 not yet", {7'd0, laser0}, 8'd0);
        @(negedge clk);
        chk("R2 after sync", {7'd0, laser0}, 8'd1);

        // R7: not-ready clears and sticks
        cyc(SETTLE);
        chk("R7 before valid", {7'd0, rd0[0]}, 8'd1);
        data_valid = 1'b1;
        @(negedge clk);
        data_valid = 1'b0; m_nr = 1'b0;
        chk("R7 cleared", {7'd0, rd0[0]}, 8'd0);
        cyc(5);
        chk("R7 sticky", {7'd0, rd0[0]}, 8'd0);

        // random patterns
        for (int k = 0; k < 60; k++) begin
            logic [4:0] p;
            p = 5'($urandom);
            pin_txdis = p[0]; pin_rs1 = p[1]; pin_rs0 = p[2];
            pin_txfault = p[3]; pin_rxlos = p[4];
            if ($urandom % 2) wr(8'($urandom));
            if ($urandom % 4 == 0) begin
                data_valid = 1'b1; @(negedge clk); data_valid = 1'b0;
            end
            cyc(SETTLE);
            check_all("R6 random");
        end

        // R4: reset again restores soft bits and not-ready
        wr(8'hFF);
        rst_n = 1'b0; m_tx = 1'b0; m_rate = 1'b0; m_nr = 1'b1;
        cyc(2);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R4 re-reset byte", rd0, 8'h01);
        cyc(SETTLE);
        check_all("R7 after re-reset");

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule